// File: doc/BRIEF.md
# Pipelined Multibit Trie Route Lookup

This block resolves 32-bit IPv4 destination addresses against a fixed-stride, leaf-pushed multibit trie. Each trie level sits in its own pipeline stage with a private node memory. A lookup enters at the first stage and walks down one level per cycle. It leaves the last stage carrying an index into a next-hop table that lives outside this block. An index of zero means that no route matches.

Route changes reach the memories through the same pipeline. A write bubble carries, for every stage, an optional address and node value. It occupies one pipeline slot and writes each stage's memory as it passes that stage. Lookups that entered behind the bubble therefore see the new table. Lookups that entered ahead of it see the old one.

Both inputs use valid/ready. A bubble is always accepted (`bub_ready` is tied high). A lookup is accepted only in a cycle in which no bubble is offered. The source must hold `lk_valid` and `lk_dst` stable until it sees `lk_ready` high at a clock edge. The result side has no back-pressure: `res_valid` is a one-cycle strobe.

Top module: `trie_lookup_pipe`

## Requirements
- R1: While reset is asserted, every node memory is cleared to a null leaf. A null leaf has bit EW-1 set and a zero payload. Out of reset, `res_valid` stays low until a lookup has been accepted. A lookup on an empty table returns `res_nh`=0 with `res_miss`=1.
- R2: The result for a lookup is presented on the LEVELS+1-th rising edge, counting the edge that accepts the lookup as the first.
- R3: Stage 0 reads the address given by the top STRIDE[0] bits of `lk_dst`. After a pointer entry at stage k, stage k+1 reads at (child base + the next STRIDE[k+1] bits of `lk_dst`), taken modulo 2^AW.
- R4: A node entry is EW bits wide. Bit EW-1 is the leaf flag. A leaf holds the next-hop index in bits NHW-1:0. A pointer holds its child base in bits AW-1:0. `res_miss` is 1 exactly when the returned index is 0.
- R5: Once a lookup reaches a leaf, the stages after it leave its index unchanged, whatever those stages contain.
- R6: A pointer entry read in the last stage returns a miss.
- R7: Lane k of a bubble is `bub_wen[k]`, `bub_waddr[k*AW +: AW]` and `bub_wdata[k*EW +: EW]`. Stage k writes only lane k, and only if `bub_wen[k]` is 1. Disabled lanes change nothing.
- R8: `bub_ready` is always 1. `lk_ready` is 0 in every cycle in which `bub_valid` is 1, so a competing bubble takes the slot.
- R9: A lookup accepted after a bubble sees that bubble's writes in every stage. A lookup accepted before it sees the old contents.
- R10: Lookups may be accepted on consecutive cycles. Each accepted lookup produces exactly one result, and results leave in the order the lookups were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup accepted this cycle when high with lk_valid |
| lk_dst | input | 32 | Destination address to resolve |
| bub_valid | input | 1 | Write bubble valid |
| bub_ready | output | 1 | Always 1 |
| bub_wen | input | LEVELS | Per-stage write enable |
| bub_waddr | input | LEVELS*AW | Per-stage write address, lane k at k*AW |
| bub_wdata | input | LEVELS*EW | Per-stage node value, lane k at k*EW |
| res_valid | output | 1 | Result strobe |
| res_nh | output | NHW | Next-hop index |
| res_miss | output | 1 | No matching route |

## Verification
Suppose a stage memory holds a wrong entry, or computes a wrong child address. That fault shows up only in lookups whose path crosses the entry. Such a lookup returns a wrong index or a wrong miss flag LEVELS+1 edges after it is accepted, and the stimulus therefore routes paths through every stage and through both leaf depths. If a slot is lost, duplicated or reordered, the result count or the result order breaks within the same latency. Back-to-back lookups placed around a bubble expose a write that lands one slot too early or too late.

// File: rtl/trie_pkg.sv
package trie_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_LOOK = 2'd1,
    SLOT_BUB  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/trie_arbiter.sv
module trie_arbiter
  import trie_pkg::*;
#(
  parameter int LEVELS    = 4,
  parameter int AW        = 8,
  parameter int NHW       = 8,
  parameter int EW        = 9,
  parameter int S0_SHIFT  = 24,
  parameter int S0_STRIDE = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  output logic                   lk_ready,
  input  logic [31:0]            lk_dst,
  input  logic                   bub_valid,
  output logic                   bub_ready,
  input  logic [LEVELS-1:0]      bub_wen,
  input  logic [LEVELS*AW-1:0]   bub_waddr,
  input  logic [LEVELS*EW-1:0]   bub_wdata,
  output slot_kind_e             o_kind,
  output logic [31:0]            o_dst,
  output logic [AW-1:0]          o_addr,
  output logic                   o_done,
  output logic [NHW-1:0]         o_nh,
  output logic [LEVELS-1:0]      o_wen,
  output logic [LEVELS*AW-1:0]   o_waddr,
  output logic [LEVELS*EW-1:0]   o_wdata
);
  localparam logic [31:0] MASK0 = (S0_STRIDE >= 32) ? '1 : ((32'd1 << S0_STRIDE) - 32'd1);

  logic [31:0] root_bits;

  assign bub_ready = 1'b1;
  assign lk_ready  = ~bub_valid;
  assign root_bits = (lk_dst >> S0_SHIFT) & MASK0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_kind  <= SLOT_IDLE;
      o_dst   <= '0;
      o_addr  <= '0;
      o_done  <= 1'b0;
      o_nh    <= '0;
      o_wen   <= '0;
      o_waddr <= '0;
      o_wdata <= '0;
    end else begin
      o_done <= 1'b0;
      o_nh   <= '0;
      if (bub_valid) begin
        o_kind  <= SLOT_BUB;
        o_wen   <= bub_wen;
        o_waddr <= bub_waddr;
        o_wdata <= bub_wdata;
      end else if (lk_valid) begin
        o_kind <= SLOT_LOOK;
        o_dst  <= lk_dst;
        o_addr <= root_bits[AW-1:0];
        o_wen  <= '0;
      end else begin
        o_kind <= SLOT_IDLE;
        o_wen  <= '0;
      end
    end
  end

  // R8
  bubble_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bub_valid |=> (o_kind == SLOT_BUB));

  // R10
  lookup_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (o_kind == SLOT_LOOK && o_dst == $past(lk_dst)));
endmodule

// File: rtl/trie_stage.sv
module trie_stage
  import trie_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int SIDX       = 0,
  parameter int AW         = 8,
  parameter int NHW        = 8,
  parameter int EW         = 9,
  parameter int NXT_SHIFT  = 16,
  parameter int NXT_STRIDE = 8,
  parameter bit LAST       = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  slot_kind_e           i_kind,
  input  logic [31:0]          i_dst,
  input  logic [AW-1:0]        i_addr,
  input  logic                 i_done,
  input  logic [NHW-1:0]       i_nh,
  input  logic [LEVELS-1:0]    i_wen,
  input  logic [LEVELS*AW-1:0] i_waddr,
  input  logic [LEVELS*EW-1:0] i_wdata,
  output slot_kind_e           o_kind,
  output logic [31:0]          o_dst,
  output logic [AW-1:0]        o_addr,
  output logic                 o_done,
  output logic [NHW-1:0]       o_nh,
  output logic [LEVELS-1:0]    o_wen,
  output logic [LEVELS*AW-1:0] o_waddr,
  output logic [LEVELS*EW-1:0] o_wdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] NMASK = (NXT_STRIDE >= 32) ? '1 : ((32'd1 << NXT_STRIDE) - 32'd1);
  localparam logic [EW-1:0] NULL_LEAF = {1'b1, {(EW-1){1'b0}}};

  logic [EW-1:0]   node_mem [DEPTH];
  logic [EW-1:0]   rd;
  logic [31:0]     nxt_bits;
  logic [AW-1:0]   nx_addr;
  logic            nx_done;
  logic [NHW-1:0]  nx_nh;
  logic            my_we;
  logic [AW-1:0]   my_waddr;
  logic [EW-1:0]   my_wdata;

  assign rd       = node_mem[i_addr];
  assign nxt_bits = (i_dst >> NXT_SHIFT) & NMASK;
  assign my_we    = (i_kind == SLOT_BUB) && i_wen[SIDX];
  assign my_waddr = i_waddr[SIDX*AW +: AW];
  assign my_wdata = i_wdata[SIDX*EW +: EW];

  always_comb begin
    nx_addr = i_addr;
    nx_done = i_done;
    nx_nh   = i_nh;
    if (i_kind == SLOT_LOOK && !i_done) begin
      if (rd[EW-1]) begin
        nx_done = 1'b1;
        nx_nh   = rd[NHW-1:0];
      end else if (LAST) begin
        nx_done = 1'b1;
        nx_nh   = '0;
      end else begin
        nx_addr = rd[AW-1:0] + nxt_bits[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) node_mem[i] <= NULL_LEAF;
    end else if (my_we) begin
      node_mem[my_waddr] <= my_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_kind  <= SLOT_IDLE;
      o_dst   <= '0;
      o_addr  <= '0;
      o_done  <= 1'b0;
      o_nh    <= '0;
      o_wen   <= '0;
      o_waddr <= '0;
      o_wdata <= '0;
    end else begin
      o_kind  <= i_kind;
      o_dst   <= i_dst;
      o_addr  <= nx_addr;
      o_done  <= nx_done;
      o_nh    <= nx_nh;
      o_wen   <= i_wen;
      o_waddr <= i_waddr;
      o_wdata <= i_wdata;
    end
  end

  // R5
  leaf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_kind == SLOT_LOOK && i_done) |=> (o_done && o_nh == $past(i_nh)));

  // R10
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (o_kind == $past(i_kind)));

  // R7
  write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    my_we |=> (node_mem[$past(my_waddr)] == $past(my_wdata)));
endmodule

// File: rtl/trie_lookup_pipe.sv
module trie_lookup_pipe
  import trie_pkg::*;
#(
  parameter int LEVELS         = 4,
  parameter int STRIDE[LEVELS] = '{8, 8, 8, 8},
  parameter int AW             = 8,
  parameter int NHW            = 8,
  localparam int PW            = (AW > NHW) ? AW : NHW,
  localparam int EW            = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic [31:0]          lk_dst,
  input  logic                 bub_valid,
  output logic                 bub_ready,
  input  logic [LEVELS-1:0]    bub_wen,
  input  logic [LEVELS*AW-1:0] bub_waddr,
  input  logic [LEVELS*EW-1:0] bub_wdata,
  output logic                 res_valid,
  output logic [NHW-1:0]       res_nh,
  output logic                 res_miss
);
  function automatic int stride_sum(int n);
    int s = 0;
    for (int i = 0; i < LEVELS; i++) if (i < n) s += STRIDE[i];
    return s;
  endfunction

  function automatic int stride_at(int n);
    int s = 0;
    for (int i = 0; i < LEVELS; i++) if (i == n) s = STRIDE[i];
    return s;
  endfunction

  localparam int CW = $clog2(LEVELS + 2) + 1;

  slot_kind_e           kind_c  [LEVELS+1];
  logic [31:0]          dst_c   [LEVELS+1];
  logic [AW-1:0]        addr_c  [LEVELS+1];
  logic                 done_c  [LEVELS+1];
  logic [NHW-1:0]       nh_c    [LEVELS+1];
  logic [LEVELS-1:0]    wen_c   [LEVELS+1];
  logic [LEVELS*AW-1:0] waddr_c [LEVELS+1];
  logic [LEVELS*EW-1:0] wdata_c [LEVELS+1];

  trie_arbiter #(
    .LEVELS(LEVELS), .AW(AW), .NHW(NHW), .EW(EW),
    .S0_SHIFT(32 - stride_at(0)), .S0_STRIDE(stride_at(0))
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_dst(lk_dst),
    .bub_valid(bub_valid), .bub_ready(bub_ready),
    .bub_wen(bub_wen), .bub_waddr(bub_waddr), .bub_wdata(bub_wdata),
    .o_kind(kind_c[0]), .o_dst(dst_c[0]), .o_addr(addr_c[0]),
    .o_done(done_c[0]), .o_nh(nh_c[0]), .o_wen(wen_c[0]),
    .o_waddr(waddr_c[0]), .o_wdata(wdata_c[0])
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_stage
    localparam bit IS_LAST = (g == LEVELS - 1);
    trie_stage #(
      .LEVELS(LEVELS), .SIDX(g), .AW(AW), .NHW(NHW), .EW(EW),
      .NXT_SHIFT(IS_LAST ? 0 : 32 - stride_sum(g + 2)),
      .NXT_STRIDE(IS_LAST ? 0 : stride_at(g + 1)),
      .LAST(IS_LAST)
    ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .i_kind(kind_c[g]), .i_dst(dst_c[g]), .i_addr(addr_c[g]),
      .i_done(done_c[g]), .i_nh(nh_c[g]), .i_wen(wen_c[g]),
      .i_waddr(waddr_c[g]), .i_wdata(wdata_c[g]),
      .o_kind(kind_c[g+1]), .o_dst(dst_c[g+1]), .o_addr(addr_c[g+1]),
      .o_done(done_c[g+1]), .o_nh(nh_c[g+1]), .o_wen(wen_c[g+1]),
      .o_waddr(waddr_c[g+1]), .o_wdata(wdata_c[g+1])
    );
  end

  assign res_valid = (kind_c[LEVELS] == SLOT_LOOK);
  assign res_nh    = nh_c[LEVELS];
  assign res_miss  = res_valid && (nh_c[LEVELS] == '0);

  logic [CW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(lk_valid && lk_ready) - CW'(res_valid);
  end

  // R10
  no_orphan_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight != '0));

  // R2
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LEVELS + 1));

  // R2
  result_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done_c[LEVELS]);
endmodule

// File: tb/trie_lookup_pipe_tb.sv
module trie_lookup_pipe_tb;
  localparam int LEVELS = 4;
  localparam int AW = 8;
  localparam int NHW = 8;
  localparam int EW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_dst = '0;
  logic bub_valid = 1'b0;
  logic [LEVELS-1:0] bub_wen = '0;
  logic [LEVELS*AW-1:0] bub_waddr = '0;
  logic [LEVELS*EW-1:0] bub_wdata = '0;
  logic lk_ready, bub_ready, res_valid, res_miss;
  logic [NHW-1:0] res_nh;

  always #5 clk = ~clk;

  trie_lookup_pipe u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_dst(lk_dst),
    .bub_valid(bub_valid), .bub_ready(bub_ready),
    .bub_wen(bub_wen), .bub_waddr(bub_waddr), .bub_wdata(bub_wdata),
    .res_valid(res_valid), .res_nh(res_nh), .res_miss(res_miss)
  );

  int n_tests = 0;
  int n_fail = 0;
  logic [NHW-1:0] log_nh [64];
  logic log_miss [64];
  int log_n = 0;

  always @(negedge clk) begin
    if (rst_n && res_valid && log_n < 64) begin
      log_nh[log_n] = res_nh;
      log_miss[log_n] = res_miss;
      log_n = log_n + 1;
    end
  end

  // {dst, expected next-hop index}; 0 means miss
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {32'h0A01_0000, 8'h07},
    {32'h0A02_0304, 8'h09},
    {32'h0A02_0305, 8'h0A},
    {32'h0A02_0306, 8'h00},
    {32'h0B00_0000, 8'h05},
    {32'h0BFF_FFFF, 8'h05},
    {32'h0C00_0000, 8'h00},
    {32'h0D00_0000, 8'h00},
    {32'h0A03_0000, 8'h00}
  };

  function automatic logic [EW-1:0] leaf(input logic [7:0] nh);
    return {1'b1, nh};
  endfunction
  function automatic logic [EW-1:0] ptr(input logic [7:0] base);
    return {1'b0, base};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] dst);
    lk_valid = 1'b1;
    lk_dst = dst;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic bubble(input logic [3:0] en, input logic [31:0] addrs, input logic [35:0] datas);
    bub_valid = 1'b1;
    bub_wen = en;
    bub_waddr = addrs;
    bub_wdata = datas;
    @(negedge clk);
    bub_valid = 1'b0;
    bub_wen = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    check("R1 no result in reset", 32'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle result", 32'(res_valid), 0);
    check("R8 bub_ready", 32'(bub_ready), 1);
    check("R8 lk_ready idle", 32'(lk_ready), 1);

    // R2 latency and R1 empty-table miss
    base = log_n;
    lookup(32'h0A01_0000);
    repeat (3) @(negedge clk);
    check("R2 not early", 32'(res_valid), 0);
    @(negedge clk);
    check("R2 on time", 32'(res_valid), 1);
    check("R1 empty nh", 32'(res_nh), 0);
    check("R1 empty miss", 32'(res_miss), 1);
    @(negedge clk);

    // program table; lane order s3,s2,s1,s0
    bubble(4'b1111, {8'h34, 8'h13, 8'h21, 8'h0A},
           {leaf(8'h09), ptr(8'h30), leaf(8'h07), ptr(8'h20)});
    // stage 2 lane disabled but filled with a decoy write (R7)
    bubble(4'b1011, {8'h35, 8'h13, 8'h22, 8'h0B},
           {leaf(8'h0A), leaf(8'h33), ptr(8'h10), leaf(8'h05)});
    // pointer in last stage -> miss
    bubble(4'b1111, {8'h90, 8'h80, 8'h40, 8'h0C},
           {ptr(8'h00), ptr(8'h90), ptr(8'h80), ptr(8'h40)});
    repeat (6) @(negedge clk);

    base = log_n;
    lookup(32'h0A02_0304);
    repeat (8) @(negedge clk);
    check("R7 disabled lane untouched", 32'(log_nh[base]), 32'h09);

    // vector table, issued back to back
    base = log_n;
    for (int i = 0; i < NV; i++) lookup(VEC[i][39:8]);
    repeat (8) @(negedge clk);
    check("R10 result count", 32'(log_n - base), NV);
    for (int i = 0; i < NV; i++) begin
      check($sformatf("R3/R4/R5/R6 vector %0d nh", i), 32'(log_nh[base+i]), 32'(VEC[i][7:0]));
      check($sformatf("R4 vector %0d miss", i), 32'(log_miss[base+i]), 32'(VEC[i][7:0] == 8'h00));
    end

    // R9 ordering around a bubble
    base = log_n;
    lookup(32'h0A02_0304);
    bubble(4'b1000, {8'h34, 8'h00, 8'h00, 8'h00}, {leaf(8'h44), 27'h0});
    lookup(32'h0A02_0304);
    repeat (8) @(negedge clk);
    check("R9 count", 32'(log_n - base), 2);
    check("R9 older sees old", 32'(log_nh[base]), 32'h09);
    check("R9 newer sees new", 32'(log_nh[base+1]), 32'h44);

    // R8 bubble and lookup offered together
    base = log_n;
    bub_valid = 1'b1;
    bub_wen = 4'b0010;
    bub_waddr = {8'h00, 8'h00, 8'h21, 8'h00};
    bub_wdata = {9'h0, 9'h0, leaf(8'h17), 9'h0};
    lk_valid = 1'b1;
    lk_dst = 32'h0A01_0000;
    #1;
    check("R8 lookup stalled", 32'(lk_ready), 0);
    check("R8 bubble taken", 32'(bub_ready), 1);
    @(negedge clk);
    bub_valid = 1'b0;
    bub_wen = '0;
    #1;
    check("R8 lookup ready after", 32'(lk_ready), 1);
    @(negedge clk);
    lk_valid = 1'b0;
    repeat (8) @(negedge clk);
    check("R8 single result", 32'(log_n - base), 1);
    check("R8 lookup after bubble", 32'(log_nh[base]), 32'h17);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule